// File: doc/BRIEF.md
# ADC Conversion Sequencer with Buffered Channel Selection

This block runs the digital side of a successive-approximation converter from a single converter clock. A conversion can be launched by a software start strobe or, when hardware triggering is enabled, by a trigger pulse. The block counts converter clocks through the sampling phase and the ten bit trials, and presents the trial code to an external DAC. It resolves the result from a single comparator bit and then raises a sticky completion flag.

Software writes the channel and reference selection into a staging register at any time. The selection seen by the analog front end follows the staging register on every idle clock. It stays frozen from the start of a conversion until its final clock, so the sampling window always uses a consistent selection. The first conversion after the block is enabled is a long one. Later conversions are short, and hardware-triggered ones take one clock more than software ones. Sampling ends a fixed 11 clocks before completion in every mode.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, busy_o, done_o, hold_o, trial_o, result_o, chan_o and vref_o are all zero.
- R2: While no conversion runs, a selection written via sel_wr_i is held in staging at the next edge and appears on chan_o/vref_o one edge later.
- R3: From the edge that starts a conversion until its final cycle, chan_o and vref_o do not change, even if new selections are written.
- R4: At the edge where done_o rises, chan_o/vref_o take the staged selection, including one written during the conversion.
- R5: A start_i pulse sampled at an edge while enabled and idle raises busy_o at that same edge; start_i is ignored while en_i is low.
- R6: The first conversion after enable ends (done_o rises) 25 edges after busy_o rises; hold_o rises 14 edges after busy_o rises.
- R7: A later software-started conversion ends 13 edges after busy_o rises, with hold_o rising after 2 edges.
- R8: With auto_en_i high, a trig_i pulse starts a conversion that ends after 14 edges, with hold_o rising after 3; with auto_en_i low, trig_i is ignored.
- R9: When hold_o rises, trial_o is 10'h200. Bits are then tried MSB first, one per edge, and a bit is kept when cmp_i is high. With a comparator that reports trial_o <= V, the result equals V.
- R10: result_o changes only at the edge where done_o is set. done_o stays set until a done_clr_i pulse clears it.
- R11: busy_o drops at the edge where done_o rises; hold_o is high only while busy_o is high.
- R12: A trig_i pulse arriving during a conversion neither lengthens it nor queues a later conversion.
- R13: Dropping en_i clears busy_o at the next edge without setting done_o. The next conversion after re-enabling is treated as a first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| start_i | input | 1 | Software start strobe |
| auto_en_i | input | 1 | Hardware trigger enable |
| trig_i | input | 1 | Hardware trigger pulse |
| sel_wr_i | input | 1 | Write strobe for the staging selection |
| chan_i | input | 6 | Channel value to stage |
| vref_i | input | 3 | Reference value to stage |
| done_clr_i | input | 1 | Clear strobe for the completion flag |
| cmp_i | input | 1 | Comparator output for the current trial |
| chan_o | output | 6 | Active channel selection |
| vref_o | output | 3 | Active reference selection |
| hold_o | output | 1 | High once the sample is taken, until completion |
| trial_o | output | 10 | Current successive-approximation trial code |
| result_o | output | 10 | Last completed result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Sticky completion flag |

## Verification
Some properties are checked on every cycle. The selection stays stable through the locked part of a conversion. busy_o can rise only from a qualified request and falls whenever the enable is dropped. The result moves only together with a completion, done_o holds until it is cleared, and hold_o never appears outside a conversion. Other behaviour needs the bench's scenarios: the exact length of each mode and the position of the sample point, convergence of the bit trials to a known analog level, and the hand-over of a selection written during a conversion. Beyond those, only scenarios can show that a trigger during a conversion is not queued, and that an abort makes the next conversion long again.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Which timing profile the running conversion follows
  typedef enum logic [1:0] {
    MODE_FIRST = 2'd0,
    MODE_SOFT  = 2'd1,
    MODE_HW    = 2'd2
  } conv_mode_e;

endpackage

// File: rtl/adc_sel_buf.sv
module adc_sel_buf #(
  parameter int CH_W  = 6,
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [REF_W-1:0] rf_i,
  input  logic             lock_i,
  output logic [CH_W-1:0]  ch_o,
  output logic [REF_W-1:0] rf_o
);

  logic [CH_W-1:0]  ch_stage;
  logic [REF_W-1:0] rf_stage;

  // Staging register: open to the CPU on every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_stage <= '0;
      rf_stage <= '0;
    end else if (wr_i) begin
      ch_stage <= ch_i;
      rf_stage <= rf_i;
    end
  end

  // Active copy follows staging except while the converter holds it
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_o <= '0;
      rf_o <= '0;
    end else if (!lock_i) begin
      ch_o <= ch_stage;
      rf_o <= rf_stage;
    end
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int FIRST_CYC = 25,
  parameter int SOFT_CYC  = 13,
  parameter int HW_CYC    = 14,
  parameter int RES_W     = 10,
  localparam int IDX_W    = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             sw_req_i,
  input  logic             hw_req_i,
  output logic             busy_o,
  output logic             hold_o,
  output logic             smp_o,
  output logic             bit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  localparam int MAX_A = (FIRST_CYC > SOFT_CYC) ? FIRST_CYC : SOFT_CYC;
  localparam int MAX_C = (MAX_A > HW_CYC) ? MAX_A : HW_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TAIL    = CNT_W'(RES_W + 1);
  localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(FIRST_CYC);
  localparam logic [CNT_W-1:0] SOFT_C  = CNT_W'(SOFT_CYC);
  localparam logic [CNT_W-1:0] HW_C    = CNT_W'(HW_CYC);

  conv_mode_e       mode_q;
  logic             first_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] smp_pt;
  logic             run;

  always_comb begin
    case (mode_q)
      MODE_FIRST: len = FIRST_C;
      MODE_HW:    len = HW_C;
      default:    len = SOFT_C;
    endcase
  end

  // Sampling closes a fixed tail of clocks before completion
  assign smp_pt = len - TAIL;
  assign run    = en_i && busy_o;
  assign last_o = run && (cnt_q == len);
  assign smp_o  = run && (cnt_q == smp_pt);
  assign bit_o  = run && (cnt_q > smp_pt) && (cnt_q < len);
  assign idx_o  = IDX_W'(len - cnt_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      hold_o  <= 1'b0;
      cnt_q   <= '0;
      first_q <= 1'b1;
      mode_q  <= MODE_FIRST;
    end else if (!en_i) begin
      busy_o  <= 1'b0;
      hold_o  <= 1'b0;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (!busy_o) begin
      if (sw_req_i || hw_req_i) begin
        busy_o  <= 1'b1;
        cnt_q   <= ONE;
        first_q <= 1'b0;
        if (first_q)       mode_q <= MODE_FIRST;
        else if (sw_req_i) mode_q <= MODE_SOFT;
        else               mode_q <= MODE_HW;
      end
    end else if (last_o) begin
      busy_o <= 1'b0;
      hold_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
      if (smp_o) hold_o <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_W  = 10,
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_i,
  input  logic             bit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             last_i,
  input  logic             cmp_i,
  input  logic             clr_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trial_nxt;

  // Decide the bit under test, then raise the next lower one
  always_comb begin
    trial_nxt = trial_o;
    if (!cmp_i) trial_nxt[idx_i] = 1'b0;
    if (idx_i != '0) trial_nxt[idx_i - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_o  <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      if (smp_i)      trial_o <= TOP_BIT;
      else if (bit_i) trial_o <= trial_nxt;
      if (last_i) begin
        result_o <= trial_o;
        done_o   <= 1'b1;
      end else if (clr_i) begin
        done_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CH_W      = 6,
  parameter int REF_W     = 3,
  parameter int RES_W     = 10,
  parameter int FIRST_CYC = 25,
  parameter int SOFT_CYC  = 13,
  parameter int HW_CYC    = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             auto_en_i,
  input  logic             trig_i,
  input  logic             sel_wr_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [REF_W-1:0] vref_i,
  input  logic             done_clr_i,
  input  logic             cmp_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [REF_W-1:0] vref_o,
  output logic             hold_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic             smp;
  logic             bit_en;
  logic             last;
  logic [IDX_W-1:0] idx;
  logic             lock;

  // Frozen from the start edge until the final cycle of a conversion
  assign lock = en_i && busy_o && !last;

  adc_seq_timer #(
    .FIRST_CYC(FIRST_CYC),
    .SOFT_CYC (SOFT_CYC),
    .HW_CYC   (HW_CYC),
    .RES_W    (RES_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .sw_req_i(start_i),
    .hw_req_i(auto_en_i && trig_i),
    .busy_o  (busy_o),
    .hold_o  (hold_o),
    .smp_o   (smp),
    .bit_o   (bit_en),
    .idx_o   (idx),
    .last_o  (last)
  );

  adc_sel_buf #(
    .CH_W (CH_W),
    .REF_W(REF_W)
  ) u_sel (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (sel_wr_i),
    .ch_i  (chan_i),
    .rf_i  (vref_i),
    .lock_i(lock),
    .ch_o  (chan_o),
    .rf_o  (vref_o)
  );

  adc_sar_reg #(
    .RES_W(RES_W)
  ) u_sar (
    .clk     (clk),
    .rst     (rst),
    .smp_i   (smp),
    .bit_i   (bit_en),
    .idx_i   (idx),
    .last_i  (last),
    .cmp_i   (cmp_i),
    .clr_i   (done_clr_i),
    .trial_o (trial_o),
    .result_o(result_o),
    .done_o  (done_o)
  );

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int CH_W  = 6,
  parameter int REF_W = 3,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             start_i,
  input logic             auto_en_i,
  input logic             trig_i,
  input logic             done_clr_i,
  input logic [CH_W-1:0]  chan_o,
  input logic [REF_W-1:0] vref_o,
  input logic             hold_o,
  input logic [RES_W-1:0] result_o,
  input logic             busy_o,
  input logic             done_o
);

  // R3
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(chan_o) && $stable(vref_o)));

  // R5
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(en_i) && ($past(start_i) || ($past(auto_en_i) && $past(trig_i)))));

  // R10
  result_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> ($fell(busy_o) && done_o));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !done_clr_i) |=> done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !busy_o);

  // R11
  hold_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> busy_o);

  // R13
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !busy_o);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .CH_W (CH_W),
  .REF_W(REF_W),
  .RES_W(RES_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_i      (en_i),
  .start_i   (start_i),
  .auto_en_i (auto_en_i),
  .trig_i    (trig_i),
  .done_clr_i(done_clr_i),
  .chan_o    (chan_o),
  .vref_o    (vref_o),
  .hold_o    (hold_o),
  .result_o  (result_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_adc_conv_seq.sv
`timescale 1ns/1ps
module test_adc_conv_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0, start_i = 1'b0, auto_en_i = 1'b0, trig_i = 1'b0;
  logic       sel_wr_i = 1'b0, done_clr_i = 1'b0;
  logic [5:0] chan_i = '0;
  logic [2:0] vref_i = '0;
  logic       cmp_i;
  logic [5:0] chan_o;
  logic [2:0] vref_o;
  logic       hold_o, busy_o, done_o;
  logic [9:0] trial_o, result_o;
  logic [9:0] vin = '0;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  // Ideal comparator: the analog level is at or above the trial code
  assign cmp_i = (trial_o <= vin);

  adc_conv_seq i_adc_conv_seq (
    .clk(clk), .rst(rst), .en_i(en_i), .start_i(start_i), .auto_en_i(auto_en_i),
    .trig_i(trig_i), .sel_wr_i(sel_wr_i), .chan_i(chan_i), .vref_i(vref_i),
    .done_clr_i(done_clr_i), .cmp_i(cmp_i), .chan_o(chan_o), .vref_o(vref_o),
    .hold_o(hold_o), .trial_o(trial_o), .result_o(result_o), .busy_o(busy_o),
    .done_o(done_o)
  );

  typedef struct {
    logic [9:0] res;
    logic [5:0] ch;
    logic [2:0] rf;
    int         len;
    int         hs;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: time every conversion and compare against the queue
  logic busy_d = 1'b0, hold_d = 1'b0, done_d = 1'b0;
  int   cyc = 0, t_busy = 0, t_hold = 0;

  always @(negedge clk) begin
    cyc++;
    if (busy_o && !busy_d) t_busy = cyc;
    if (hold_o && !hold_d) begin
      t_hold = cyc;
      chk("R9", "trial at sample", int'(trial_o), 'h200);
    end
    if (done_o && !done_d) begin
      if (exp_q.size() == 0) begin
        chk("R10", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R9", "result", int'(result_o), int'(e.res));
        chk("R4", "channel at completion", int'(chan_o), int'(e.ch));
        chk("R4", "reference at completion", int'(vref_o), int'(e.rf));
        chk(e.tag, "conversion length", cyc - t_busy, e.len);
        chk(e.tag, "sample point", t_hold - t_busy, e.hs);
        chk("R11", "busy at completion", int'(busy_o), 0);
      end
    end
    busy_d = busy_o;
    hold_d = hold_o;
    done_d = done_o;
  end

  task automatic wr_sel(input logic [5:0] c, input logic [2:0] r);
    @(negedge clk); sel_wr_i = 1'b1; chan_i = c; vref_i = r;
    @(negedge clk); sel_wr_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  // Driver: push the expected item, then launch the conversion
  task automatic begin_conv(input logic hw, input logic [9:0] v, input logic [5:0] c,
                            input logic [2:0] r, input int len, input string tag);
    exp_t e;
    e.res = v; e.ch = c; e.rf = r; e.len = len; e.hs = len - 11; e.tag = tag;
    exp_q.push_back(e);
    vin = v;
    if (hw) pulse_trig(); else pulse_start();
    chk("R5", "busy after request", int'(busy_o), 1);
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic clr_done();
    @(negedge clk); done_clr_i = 1'b1;
    @(negedge clk); done_clr_i = 1'b0;
    chk("R10", "done after clear", int'(done_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "hold", int'(hold_o), 0);
    chk("R1", "result", int'(result_o), 0);
    chk("R1", "trial", int'(trial_o), 0);
    chk("R1", "channel", int'(chan_o), 0);
    chk("R1", "reference", int'(vref_o), 0);

    // R5: start ignored while disabled
    pulse_start();
    chk("R5", "busy while disabled", int'(busy_o), 0);

    // R2: idle tracking, two edges from write to active
    wr_sel(6'd5, 3'd2);
    chk("R2", "channel one edge after write", int'(chan_o), 0);
    @(negedge clk);
    chk("R2", "channel two edges after write", int'(chan_o), 5);
    chk("R2", "reference two edges after write", int'(vref_o), 2);

    // R6: first conversion; R3/R4: write during conversion
    en_i = 1'b1;
    begin_conv(1'b0, 10'h2A5, 6'd9, 3'd3, 25, "R6");
    repeat (3) @(negedge clk);
    wr_sel(6'd9, 3'd3);
    repeat (2) @(negedge clk);
    chk("R3", "channel locked", int'(chan_o), 5);
    chk("R3", "reference locked", int'(vref_o), 2);
    wait_done();
    repeat (3) @(negedge clk);
    chk("R10", "done sticky", int'(done_o), 1);
    chk("R10", "result held", int'(result_o), 'h2A5);
    clr_done();

    // R7: normal software conversions at the code extremes
    begin_conv(1'b0, 10'h3FF, 6'd9, 3'd3, 13, "R7");
    wait_done();
    clr_done();
    begin_conv(1'b0, 10'h000, 6'd9, 3'd3, 13, "R7");
    wait_done();
    clr_done();

    // R8: trigger ignored without auto enable
    pulse_trig();
    chk("R8", "busy from trigger with auto off", int'(busy_o), 0);

    // R8/R12: triggered conversion with a trigger arriving mid-way
    auto_en_i = 1'b1;
    begin_conv(1'b1, 10'h155, 6'd9, 3'd3, 14, "R8");
    repeat (3) @(negedge clk);
    pulse_trig();
    wait_done();
    repeat (3) @(negedge clk);
    chk("R12", "no queued conversion", int'(busy_o), 0);
    clr_done();
    auto_en_i = 1'b0;

    // R13: abort, then the next conversion is long again
    vin = 10'h0F0;
    pulse_start();
    repeat (5) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk("R13", "busy after disable", int'(busy_o), 0);
    chk("R13", "done after abort", int'(done_o), 0);
    en_i = 1'b1;
    begin_conv(1'b0, 10'h0C3, 6'd9, 3'd3, 25, "R13");
    wait_done();
    clr_done();

    repeat (2) @(negedge clk);
    chk("R10", "all expected completions seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule